// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block is the keyboard-facing pair of device registers on a 16-bit memory-mapped bus. A keyboard source presents an 8-bit character code together with a one-cycle strobe. The block captures the code into a data register and raises a ready flag in a status register. Until software reads the data register, the keyboard side stays locked out and later strobes are discarded. The read that fetches the character clears the ready flag and opens the port for the next key.

The processor reaches the port through two fixed bus addresses: the status register at 0xFE00 and the data register at 0xFE02. Read data and a read-select output are combinational. The select tells the memory data path to load from this port and not from memory. A software-set interrupt-enable bit in the status register lets the port request an interrupt whenever a character is waiting.

Top module: `kbd_port`

## Requirements
- R1: After the asynchronous active-low reset, the ready flag, the interrupt-enable bit, the captured character and `irq_o` are all zero.
- R2: A strobe on `key_valid_i` while the ready flag is clear latches `key_char_i` as the captured character. From the next cycle the ready flag (status bit 15) reads as one.
- R3: While the ready flag is set, strobes are dropped and the captured character does not change.
- R4: A bus read at 0xFE02 clears the ready flag at the next clock edge, and the keyboard is accepted again from then on.
- R5: A read at 0xFE02 returns the captured character in bits [7:0], with bits [15:8] as zero.
- R6: A read at 0xFE00 returns the ready flag in bit 15 and the interrupt-enable bit in bit 14. All other bits are zero.
- R7: A bus write at 0xFE00 loads bit 14 of `bus_wdata_i` into the interrupt-enable bit at the next edge. The write leaves the ready flag unchanged.
- R8: A bus write at 0xFE02 has no effect on the captured character or on either status bit.
- R9: `irq_o` is one exactly when both the ready flag and the interrupt-enable bit are one. It follows them one cycle after the strobe, read or write that changes them.
- R10: `rd_sel_o` is one only while `bus_rd_i` is high and `bus_addr_i` equals 0xFE00 or 0xFE02. Otherwise `rd_sel_o` is zero and `rd_data_o` is zero.
- R11: If a strobe and a data-register read fall in the same cycle, the outcome depends on the ready flag. When the flag is set, the character is dropped and the flag clears. When the flag is clear, the character is captured and the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | One-cycle strobe for a new character |
| key_char_i | input | 8 | Character code from the keyboard |
| bus_addr_i | input | 16 | Bus address |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 16 | Bus write data |
| rd_sel_o | output | 1 | High when the current read targets this port |
| rd_data_o | output | 16 | Read data, zero when not selected |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and read-select depend only on the current address, the strobe and the registered state, so they are due in the same cycle as the read. The bench samples them one nanosecond after driving the inputs on the falling edge. Captures, ready clears, interrupt-enable writes and the resulting `irq_o` change take effect at the next rising edge. The reference model therefore applies each stimulus only after that edge, and the change is compared in the following cycle. Same-cycle collisions between a strobe and a data read are driven with the ready flag both set and clear.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned CHAR_W    = 8;
  localparam int unsigned READY_BIT = 15;
  localparam int unsigned IE_BIT    = 14;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00;
  localparam logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02;
  localparam int unsigned NUM_REGS  = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_STAT = 2'b01,
    SEL_DATA = 2'b10
  } reg_sel_e;
endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec
  import kbd_port_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] STAT_A = STAT_ADDR,
  parameter logic [AW-1:0] DATA_A = DATA_ADDR
) (
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output reg_sel_e      rd_sel_o,
  output logic          wr_stat_o,
  output logic          rd_data_o
);
  localparam logic [NUM_REGS-1:0][AW-1:0] MAP = {DATA_A, STAT_A};

  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = (addr_i == MAP[g]);
  end

  always_comb begin
    rd_sel_o = SEL_NONE;
    if (rd_i) begin
      if (hit[0])      rd_sel_o = SEL_STAT;
      else if (hit[1]) rd_sel_o = SEL_DATA;
    end
  end

  assign wr_stat_o = wr_i & hit[0];
  assign rd_data_o = rd_i & hit[1];
endmodule

// File: rtl/kbd_char_latch.sv
module kbd_char_latch #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [CW-1:0] char_i,
  input  logic          consume_i,
  output logic          ready_o,
  output logic [CW-1:0] char_o
);
  logic          ready_q;
  logic [CW-1:0] char_q;

  // lockout: a strobe is taken only while nothing is waiting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else if (valid_i && !ready_q) begin
      ready_q <= 1'b1;
      char_q  <= char_i;
    end else if (consume_i) begin
      ready_q <= 1'b0;
    end
  end

  assign ready_o = ready_q;
  assign char_o  = char_q;
endmodule

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg #(
  parameter int unsigned DW  = 16,
  parameter int unsigned IEB = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o
);
  localparam logic [DW-1:0] WR_MASK = DW'(1) << IEB;

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & WR_MASK;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/kbd_port.sv
module kbd_port
  import kbd_port_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned CW  = CHAR_W,
  parameter int unsigned RDB = READY_BIT,
  parameter int unsigned IEB = IE_BIT,
  parameter logic [AW-1:0] STAT_A = STAT_ADDR,
  parameter logic [AW-1:0] DATA_A = DATA_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_valid_i,
  input  logic [CW-1:0] key_char_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic          rd_sel_o,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  reg_sel_e      sel;
  logic          wr_stat;
  logic          rd_dreg;
  logic          ready_q;
  logic [CW-1:0] char_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] stat_word;

  kbd_addr_dec #(.AW(AW), .STAT_A(STAT_A), .DATA_A(DATA_A)) u_dec (
    .addr_i    (bus_addr_i),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .rd_sel_o  (sel),
    .wr_stat_o (wr_stat),
    .rd_data_o (rd_dreg)
  );

  kbd_char_latch #(.CW(CW)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (key_valid_i),
    .char_i    (key_char_i),
    .consume_i (rd_dreg),
    .ready_o   (ready_q),
    .char_o    (char_q)
  );

  kbd_ctrl_reg #(.DW(DW), .IEB(IEB)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_stat),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  assign stat_word = ctrl_q | (DW'(ready_q) << RDB);

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_data_o = stat_word;
      SEL_DATA: rd_data_o = DW'(char_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign rd_sel_o = (sel != SEL_NONE);
  assign irq_o    = ready_q & ctrl_q[IEB];
endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8,
  parameter logic [AW-1:0] STAT_A = 16'hFE00,
  parameter logic [AW-1:0] DATA_A = 16'hFE02
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          key_valid_i,
  input logic [CW-1:0] key_char_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_rd_i,
  input logic          bus_wr_i,
  input logic          rd_sel_o,
  input logic [DW-1:0] rd_data_o,
  input logic          irq_o,
  input logic          ready_q,
  input logic [CW-1:0] char_q
);
  logic dread;
  assign dread = bus_rd_i && (bus_addr_i == DATA_A);

  p_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && !ready_q) |=> (ready_q && char_q == $past(key_char_i)));

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && ready_q) |=> $stable(char_q));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread && ready_q) |=> !ready_q);

  p_hi_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dread |-> (rd_data_o[DW-1:CW] == '0));

  p_stat_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == STAT_A && !key_valid_i && !dread)
      |=> (ready_q == $past(ready_q)));

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(key_valid_i) || $past(bus_wr_i)));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> (!rd_sel_o && rd_data_o == '0));
endmodule

bind kbd_port kbd_port_chk #(
  .AW(AW), .DW(DW), .CW(CW), .STAT_A(STAT_A), .DATA_A(DATA_A)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_valid_i (key_valid_i),
  .key_char_i  (key_char_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .rd_sel_o    (rd_sel_o),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .ready_q     (ready_q),
  .char_q      (char_q)
);

// File: tb/kbd_port_tb_top.sv
module kbd_port_tb_top;
  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_DATA = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kv = 1'b0;
  logic [7:0]  kc = '0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wd = '0;
  logic        rd_sel;
  logic [15:0] rd_data;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // behavioural model state
  bit       m_ready = 1'b0;
  bit       m_ie    = 1'b0;
  bit [7:0] m_char  = '0;

  always #5 clk = ~clk;

  kbd_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(kv), .key_char_i(kc),
    .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wd),
    .rd_sel_o(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive after falling edge, compare, then advance the model
  task automatic cyc(string tag, bit r, bit w, logic [15:0] a, logic [15:0] d,
                     bit v, logic [7:0] c);
    bit          e_sel;
    logic [15:0] e_data;
    @(negedge clk);
    rd = r; wr = w; addr = a; wd = d; kv = v; kc = c;
    #1;
    e_sel  = r && (a == A_STAT || a == A_DATA);
    e_data = '0;
    if (r && a == A_STAT) e_data = {m_ready, m_ie, 14'b0};
    if (r && a == A_DATA) e_data = {8'h00, m_char};
    check(tag, "rd_sel", 16'(rd_sel), 16'(e_sel));
    check(tag, "rd_data", rd_data, e_data);
    check(tag, "irq", 16'(irq), 16'(m_ready && m_ie));
    @(posedge clk);
    if (v && !m_ready) begin
      m_ready = 1'b1;
      m_char  = c;
    end else if (r && a == A_DATA) begin
      m_ready = 1'b0;
    end
    if (w && a == A_STAT) m_ie = d[14];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    cyc("R1", 1, 0, A_STAT, 0, 0, 0);
    cyc("R1", 1, 0, A_DATA, 0, 0, 0);
    // R7 / R6: enable interrupts with all-ones write
    cyc("R7", 0, 1, A_STAT, 16'hFFFF, 0, 0);
    cyc("R6", 1, 0, A_STAT, 0, 0, 0);
    // R2 / R9 capture
    cyc("R2", 0, 0, 16'h0000, 0, 1, 8'h41);
    cyc("R9", 1, 0, A_STAT, 0, 0, 0);
    // R3 drop while ready
    cyc("R3", 0, 0, 16'h0000, 0, 1, 8'h42);
    // R5 read data, R4 clears ready
    cyc("R5", 1, 0, A_DATA, 0, 0, 0);
    cyc("R4", 1, 0, A_STAT, 0, 0, 0);
    // R8 data write ignored
    cyc("R8", 0, 1, A_DATA, 16'h1234, 0, 0);
    cyc("R8", 1, 0, A_DATA, 0, 0, 0);
    cyc("R8", 1, 0, A_STAT, 0, 0, 0);
    // R7 write clearing ie while ready stays set
    cyc("R7", 0, 0, 16'h0000, 0, 1, 8'h7A);
    cyc("R7", 0, 1, A_STAT, 16'h8000, 0, 0);
    cyc("R7", 1, 0, A_STAT, 0, 0, 0);
    // R10 unmapped and neighbouring addresses
    cyc("R10", 1, 0, 16'hFE04, 0, 0, 0);
    cyc("R10", 1, 0, 16'hFE01, 0, 0, 0);
    cyc("R10", 0, 0, A_DATA, 0, 0, 0);
    // R11 collision with ready set: dropped, cleared
    cyc("R11", 1, 0, A_DATA, 0, 1, 8'h55);
    cyc("R11", 1, 0, A_STAT, 0, 0, 0);
    // R11 collision with ready clear: captured
    cyc("R11", 1, 0, A_DATA, 0, 1, 8'h66);
    cyc("R11", 1, 0, A_DATA, 0, 0, 0);
    cyc("R11", 1, 0, A_STAT, 0, 0, 0);
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 3))
        0: a = A_STAT;
        1: a = A_DATA;
        2: a = 16'hFE04;
        default: a = 16'($urandom);
      endcase
      cyc("R9", 1'($urandom), 1'($urandom_range(0, 3) == 0), a, 16'($urandom),
          1'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule